// File: doc/BRIEF.md
# Guest Branch Target Resolution Unit

This unit assists a dynamic binary translator by turning the target of a guest control transfer into the address of the native code that implements it. Indirect branches and calls look up their guest target in a small set-associative cache of guest-to-native address pairs. Run-time software loads that cache through a fill port whenever it resolves a target from its own in-memory map. A miss response tells software to consult that map, and to invoke the translator if the map misses too.

Guest calls also push a pair onto a return stack: the guest return address and the native code address that continues after the call. A guest return pops the top pair. If the popped guest address equals the actual return target, the return hits and yields the stored native address. Otherwise it is reported as a miss.

Every request gets a registered response one cycle later, produced by a small response state machine. Its states are RS_IDLE (no request in the previous cycle), RS_HIT and RS_MISS. Each cycle the machine moves to RS_IDLE when no request is present. Otherwise it moves to RS_HIT when the request resolves, and to RS_MISS when it fails to resolve, has the reserved kind, or arrives together with a flush.

Top module: `gbr_unit`

## Requirements
- R1: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high, and is low after reset. `rsp_hit` is never high without `rsp_valid`.
- R2: A branch request (kind 2'b00) whose guest address was filled with valid=1 hits and returns the filled native address.
- R3: A branch request whose guest address is not present misses and returns native address 0.
- R4: The cache has 4 ways per set, and the set index is the low 4 bits of the guest address. Four distinct addresses that share a set are all retained.
- R5: A valid fill into a full set evicts the least recently used way. Both lookup hits and fills count as use.
- R6: A valid fill of an address that is already present replaces its native address in the same way, without making a duplicate. A fill with valid=0 invalidates the matching entry.
- R7: A call (kind 2'b01) pushes the pair (`req_ret_gaddr`, `req_ret_naddr`). A later return (kind 2'b10) whose `req_gaddr` equals the top guest address hits with the stored native address.
- R8: A return whose guest address differs from the top entry misses, and the entry is still popped.
- R9: A return on an empty stack misses.
- R10: The stack holds 16 entries. A push onto a full stack overwrites the oldest entry, so after 17 pushes, 16 returns hit in newest-first order and the next return misses.
- R11: `flush` invalidates every cache entry and empties the stack in one cycle. A request made in the flush cycle is answered with a miss.
- R12: A call looks up its own guest target in the cache and reports hit/miss like a branch.
- R13: The reserved kind 2'b11 always misses and leaves the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate the cache and empty the return stack |
| req_valid | input | 1 | Lookup request strobe |
| req_kind | input | 2 | 00 branch, 01 call, 10 return, 11 reserved |
| req_gaddr | input | 32 | Guest target address (branch/call) or actual return target (return) |
| req_ret_gaddr | input | 32 | Guest return address pushed by a call |
| req_ret_naddr | input | 32 | Native continuation address pushed by a call |
| sw_fill_en | input | 1 | Software fill strobe |
| sw_fill_valid | input | 1 | 1 writes the pair, 0 invalidates the matching entry |
| sw_fill_gaddr | input | 32 | Guest address of the fill |
| sw_fill_naddr | input | 32 | Native address of the fill |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Target resolved |
| rsp_naddr | output | 32 | Native target, 0 on a miss |

## Verification
The assertions assume that `req_kind` is meaningful whenever `req_valid` is high. They also assume that `flush` is only a single-cycle strobe whose effect is seen on the next edge. The stimulus drives every input on the falling edge and holds it for one full cycle. It raises `flush` only for a single cycle, never fills the set that a same-cycle lookup is touching, and always returns `req_valid` low before it samples an idle response.

// File: rtl/gbr_pkg.sv
package gbr_pkg;
    typedef enum logic [1:0] {
        K_BRANCH = 2'b00,
        K_CALL   = 2'b01,
        K_RETURN = 2'b10,
        K_RSVD   = 2'b11
    } req_kind_e;

    typedef enum logic [1:0] {
        RS_IDLE = 2'b00,
        RS_HIT  = 2'b01,
        RS_MISS = 2'b10
    } rsp_state_e;
endpackage

// File: rtl/gbr_xlat_cache.sv
module gbr_xlat_cache #(
    parameter int GA_W = 32,
    parameter int NA_W = 32,
    parameter int SETS = 16,
    parameter int WAYS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            lk_en,
    input  logic [GA_W-1:0] lk_gaddr,
    output logic            lk_hit,
    output logic [NA_W-1:0] lk_naddr,
    input  logic            fill_en,
    input  logic            fill_valid,
    input  logic [GA_W-1:0] fill_gaddr,
    input  logic [NA_W-1:0] fill_naddr
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = GA_W - IDX_W;
    localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef logic [WAYS-1:0][AGE_W-1:0] age_vec_t;

    logic [WAYS-1:0]  vld_q  [SETS];
    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    logic [NA_W-1:0]  data_q [SETS][WAYS];
    age_vec_t         age_q  [SETS];

    // Move way t to most recent; ways younger than it age by one.
    function automatic age_vec_t touch(input age_vec_t a, input logic [AGE_W-1:0] t);
        age_vec_t r;
        for (int w = 0; w < WAYS; w++) begin
            if (AGE_W'(w) == t)  r[w] = '0;
            else if (a[w] < a[t]) r[w] = a[w] + 1'b1;
            else                 r[w] = a[w];
        end
        return r;
    endfunction

    logic [IDX_W-1:0] lk_idx, f_idx;
    logic [TAG_W-1:0] lk_tag, f_tag;
    logic [AGE_W-1:0] lk_way;

    assign lk_idx = lk_gaddr[IDX_W-1:0];
    assign lk_tag = lk_gaddr[GA_W-1:IDX_W];
    assign f_idx  = fill_gaddr[IDX_W-1:0];
    assign f_tag  = fill_gaddr[GA_W-1:IDX_W];

    always_comb begin
        lk_hit   = 1'b0;
        lk_naddr = '0;
        lk_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld_q[lk_idx][w] && tag_q[lk_idx][w] == lk_tag) begin
                lk_hit   = 1'b1;
                lk_naddr = data_q[lk_idx][w];
                lk_way   = AGE_W'(w);
            end
        end
    end

    logic             f_has_match, f_has_free;
    logic [AGE_W-1:0] f_match_way, f_free_way, f_lru_way, f_way;

    always_comb begin
        f_has_match = 1'b0;
        f_match_way = '0;
        f_has_free  = 1'b0;
        f_free_way  = '0;
        f_lru_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (vld_q[f_idx][w] && tag_q[f_idx][w] == f_tag) begin
                f_has_match = 1'b1;
                f_match_way = AGE_W'(w);
            end
            if (!vld_q[f_idx][w]) begin
                f_has_free = 1'b1;
                f_free_way = AGE_W'(w);
            end
            if (age_q[f_idx][w] == AGE_W'(WAYS - 1)) begin
                f_lru_way = AGE_W'(w);
            end
        end
        if (f_has_match)     f_way = f_match_way;
        else if (f_has_free) f_way = f_free_way;
        else                 f_way = f_lru_way;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w]  <= AGE_W'(w);
                    tag_q[s][w]  <= '0;
                    data_q[s][w] <= '0;
                end
            end
        end else if (flush) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
            end
        end else begin
            if (lk_en && lk_hit) begin
                age_q[lk_idx] <= touch(age_q[lk_idx], lk_way);
            end
            if (fill_en) begin
                if (fill_valid) begin
                    vld_q[f_idx][f_way]  <= 1'b1;
                    tag_q[f_idx][f_way]  <= f_tag;
                    data_q[f_idx][f_way] <= fill_naddr;
                    age_q[f_idx]         <= touch(age_q[f_idx], f_way);
                end else if (f_has_match) begin
                    vld_q[f_idx][f_match_way] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/gbr_ret_stack.sv
module gbr_ret_stack #(
    parameter int GA_W  = 32,
    parameter int NA_W  = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [GA_W-1:0]            push_gaddr,
    input  logic [NA_W-1:0]            push_naddr,
    input  logic                       pop,
    output logic                       top_valid,
    output logic [GA_W-1:0]            top_gaddr,
    output logic [NA_W-1:0]            top_naddr,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [GA_W-1:0]  g_q [DEPTH];
    logic [NA_W-1:0]  n_q [DEPTH];
    logic [PTR_W-1:0] ptr_q, ptr_up, ptr_dn;
    logic [CNT_W-1:0] cnt_q;

    assign ptr_up    = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    assign ptr_dn    = (ptr_q == '0) ? PTR_W'(DEPTH - 1) : ptr_q - 1'b1;
    assign top_valid = (cnt_q != '0);
    assign top_gaddr = g_q[ptr_q];
    assign top_naddr = n_q[ptr_q];
    assign count     = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                g_q[i] <= '0;
                n_q[i] <= '0;
            end
        end else if (flush) begin
            cnt_q <= '0;
        end else if (push) begin
            ptr_q      <= ptr_up;
            g_q[ptr_up] <= push_gaddr;
            n_q[ptr_up] <= push_naddr;
            if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
        end else if (pop && cnt_q != '0) begin
            ptr_q <= ptr_dn;
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/gbr_unit.sv
module gbr_unit #(
    parameter int GA_W      = 32,
    parameter int NA_W      = 32,
    parameter int SETS      = 16,
    parameter int WAYS      = 4,
    parameter int RAS_DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            req_valid,
    input  logic [1:0]      req_kind,
    input  logic [GA_W-1:0] req_gaddr,
    input  logic [GA_W-1:0] req_ret_gaddr,
    input  logic [NA_W-1:0] req_ret_naddr,
    input  logic            sw_fill_en,
    input  logic            sw_fill_valid,
    input  logic [GA_W-1:0] sw_fill_gaddr,
    input  logic [NA_W-1:0] sw_fill_naddr,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic [NA_W-1:0] rsp_naddr
);
    import gbr_pkg::*;

    localparam int CNT_W = $clog2(RAS_DEPTH + 1);

    req_kind_e kind;
    assign kind = req_kind_e'(req_kind);

    logic            is_lookup, is_call, is_ret;
    logic            c_hit, top_valid, ret_hit, res_hit;
    logic [NA_W-1:0] c_naddr, top_naddr, res_naddr;
    logic [GA_W-1:0] top_gaddr;
    logic [CNT_W-1:0] ras_count;

    assign is_lookup = req_valid && (kind == K_BRANCH || kind == K_CALL);
    assign is_call   = req_valid && kind == K_CALL   && !flush;
    assign is_ret    = req_valid && kind == K_RETURN && !flush;

    gbr_xlat_cache #(
        .GA_W(GA_W), .NA_W(NA_W), .SETS(SETS), .WAYS(WAYS)
    ) u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .lk_en      (is_lookup),
        .lk_gaddr   (req_gaddr),
        .lk_hit     (c_hit),
        .lk_naddr   (c_naddr),
        .fill_en    (sw_fill_en),
        .fill_valid (sw_fill_valid),
        .fill_gaddr (sw_fill_gaddr),
        .fill_naddr (sw_fill_naddr)
    );

    gbr_ret_stack #(
        .GA_W(GA_W), .NA_W(NA_W), .DEPTH(RAS_DEPTH)
    ) u_ras (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .push       (is_call),
        .push_gaddr (req_ret_gaddr),
        .push_naddr (req_ret_naddr),
        .pop        (is_ret),
        .top_valid  (top_valid),
        .top_gaddr  (top_gaddr),
        .top_naddr  (top_naddr),
        .count      (ras_count)
    );

    assign ret_hit = top_valid && (top_gaddr == req_gaddr);

    always_comb begin
        res_hit   = 1'b0;
        res_naddr = '0;
        unique case (kind)
            K_BRANCH, K_CALL: begin
                res_hit   = c_hit;
                res_naddr = c_naddr;
            end
            K_RETURN: begin
                res_hit   = ret_hit;
                res_naddr = top_naddr;
            end
            K_RSVD: begin
                res_hit   = 1'b0;
            end
        endcase
        if (flush) res_hit = 1'b0;
    end

    rsp_state_e state_q, state_d;
    logic [NA_W-1:0] naddr_q;

    always_comb begin
        if (!req_valid)   state_d = RS_IDLE;
        else if (res_hit) state_d = RS_HIT;
        else              state_d = RS_MISS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            naddr_q <= '0;
        end else begin
            state_q <= state_d;
            naddr_q <= (state_d == RS_HIT) ? res_naddr : '0;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        unique case (state_q)
            RS_IDLE: begin
                rsp_valid = 1'b0;
                rsp_hit   = 1'b0;
            end
            RS_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
            end
            RS_MISS: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b0;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_hit   = 1'b0;
            end
        endcase
    end
    assign rsp_naddr = naddr_q;
endmodule

// File: rtl/gbr_unit_checks.sv
module gbr_unit_checks #(
    parameter int RAS_DEPTH = 16,
    parameter int CNT_W     = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [CNT_W-1:0] ras_count
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (rsp_valid == $past(req_valid))); // R1
    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid); // R1
    AST_FLUSH_REQ_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && flush) |=> !rsp_hit); // R11
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ras_count == '0)); // R11
    AST_EMPTY_POP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b10 && ras_count == '0) |=> !rsp_hit); // R9
    AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ras_count <= CNT_W'(RAS_DEPTH)); // R10
    AST_CALL_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b01 && !flush && ras_count < CNT_W'(RAS_DEPTH))
        |=> (ras_count == $past(ras_count) + 1'b1)); // R7
    AST_RSVD_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b11) |=> (!rsp_hit && $stable(ras_count))); // R13
endmodule

bind gbr_unit gbr_unit_checks #(
    .RAS_DEPTH(RAS_DEPTH), .CNT_W($clog2(RAS_DEPTH + 1))
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .ras_count (ras_count)
);

// File: tb/gbr_unit_test.sv
`timescale 1ns/1ps
module gbr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [31:0] req_gaddr = '0, req_ret_gaddr = '0, req_ret_naddr = '0;
    logic        sw_fill_en = 1'b0, sw_fill_valid = 1'b0;
    logic [31:0] sw_fill_gaddr = '0, sw_fill_naddr = '0;
    logic        rsp_valid, rsp_hit;
    logic [31:0] rsp_naddr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gbr_unit uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_kind(req_kind), .req_gaddr(req_gaddr),
        .req_ret_gaddr(req_ret_gaddr), .req_ret_naddr(req_ret_naddr),
        .sw_fill_en(sw_fill_en), .sw_fill_valid(sw_fill_valid),
        .sw_fill_gaddr(sw_fill_gaddr), .sw_fill_naddr(sw_fill_naddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_naddr(rsp_naddr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [31:0] g, input logic [31:0] n, input logic v);
        sw_fill_en = 1'b1; sw_fill_valid = v; sw_fill_gaddr = g; sw_fill_naddr = n;
        @(negedge clk);
        sw_fill_en = 1'b0;
    endtask

    task automatic request(input logic [1:0] k, input logic [31:0] g,
                           input logic [31:0] rg, input logic [31:0] rn,
                           output logic h, output logic [31:0] n);
        req_valid = 1'b1; req_kind = k; req_gaddr = g;
        req_ret_gaddr = rg; req_ret_naddr = rn;
        @(negedge clk);
        h = rsp_hit; n = rsp_naddr;
        req_valid = 1'b0;
    endtask

    task automatic expect_lookup(input string req, input logic [1:0] k, input logic [31:0] g,
                                 input logic eh, input logic [31:0] en);
        logic h; logic [31:0] n;
        request(k, g, 32'h0, 32'h0, h, n);
        check(req, {63'd0, h}, {63'd0, eh});
        check(req, {32'd0, n}, {32'd0, (eh ? en : 32'h0)});
    endtask

    task automatic push_call(input logic [31:0] tgt, input logic [31:0] rg, input logic [31:0] rn);
        logic h; logic [31:0] n;
        request(2'b01, tgt, rg, rn, h, n);
    endtask

    task automatic do_flush;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset_and_timing;  // R1
        check("R1 reset valid", {63'd0, rsp_valid}, 64'd0);
        req_valid = 1'b1; req_kind = 2'b00; req_gaddr = 32'h1234;
        @(negedge clk);
        check("R1 valid after request", {63'd0, rsp_valid}, 64'd1);
        req_valid = 1'b0;
        @(negedge clk);
        check("R1 idle after no request", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic t_branch_basic;  // R2 R3
        fill(32'h0000_1000, 32'h8000_1000, 1'b1);
        expect_lookup("R2 branch hit", 2'b00, 32'h0000_1000, 1'b1, 32'h8000_1000);
        expect_lookup("R3 branch miss", 2'b00, 32'h0000_2000, 1'b0, 32'h0);
    endtask

    task automatic t_assoc_lru;  // R4 R5
        do_flush();
        for (int i = 1; i <= 4; i++) fill(32'h105 + (i << 8), 32'hA000 + i, 1'b1);
        for (int i = 1; i <= 4; i++)
            expect_lookup("R4 four ways kept", 2'b00, 32'h105 + (i << 8), 1'b1, 32'hA000 + i);
        // Recency now 4 newest .. 1 oldest; touch way of address 1.
        expect_lookup("R5 touch", 2'b00, 32'h205, 1'b1, 32'hA001);
        fill(32'h705, 32'hA007, 1'b1);
        expect_lookup("R5 LRU evicted", 2'b00, 32'h305, 1'b0, 32'h0);
        expect_lookup("R5 touched kept", 2'b00, 32'h205, 1'b1, 32'hA001);
        expect_lookup("R5 new entry", 2'b00, 32'h705, 1'b1, 32'hA007);
    endtask

    task automatic t_update_invalidate;  // R6
        do_flush();
        fill(32'h0A, 32'h1, 1'b1);
        fill(32'h0A, 32'h2, 1'b1);
        fill(32'h1A, 32'h3, 1'b1);
        fill(32'h2A, 32'h4, 1'b1);
        fill(32'h3A, 32'h5, 1'b1);
        expect_lookup("R6 updated value", 2'b00, 32'h0A, 1'b1, 32'h2);
        expect_lookup("R6 no duplicate", 2'b00, 32'h1A, 1'b1, 32'h3);
        expect_lookup("R6 no duplicate", 2'b00, 32'h3A, 1'b1, 32'h5);
        fill(32'h0A, 32'h0, 1'b0);
        expect_lookup("R6 invalidated", 2'b00, 32'h0A, 1'b0, 32'h0);
        expect_lookup("R6 neighbour kept", 2'b00, 32'h2A, 1'b1, 32'h4);
    endtask

    task automatic t_call_target;  // R12
        do_flush();
        fill(32'h0C0, 32'hC0C0, 1'b1);
        expect_lookup("R12 call target hit", 2'b01, 32'h0C0, 1'b1, 32'hC0C0);
        expect_lookup("R12 call target miss", 2'b01, 32'h0D0, 1'b0, 32'h0);
        do_flush();
    endtask

    task automatic t_return_stack;  // R7 R8 R9 R13
        expect_lookup("R9 empty pop", 2'b10, 32'h40, 1'b0, 32'h0);
        push_call(32'h0, 32'h40, 32'h900);
        push_call(32'h0, 32'h50, 32'hA00);
        expect_lookup("R13 reserved miss", 2'b11, 32'h50, 1'b0, 32'h0);
        expect_lookup("R7 return hit", 2'b10, 32'h50, 1'b1, 32'hA00);
        push_call(32'h0, 32'h60, 32'hB00);
        expect_lookup("R8 mismatch miss", 2'b10, 32'h77, 1'b0, 32'h0);
        expect_lookup("R8 popped anyway", 2'b10, 32'h40, 1'b1, 32'h900);
        expect_lookup("R9 empty again", 2'b10, 32'h40, 1'b0, 32'h0);
    endtask

    task automatic t_overflow;  // R10
        for (int i = 0; i <= 16; i++) push_call(32'h0, 32'h300 + i, 32'h1000 + i);
        for (int i = 16; i >= 1; i--)
            expect_lookup("R10 newest first", 2'b10, 32'h300 + i, 1'b1, 32'h1000 + i);
        expect_lookup("R10 oldest overwritten", 2'b10, 32'h300, 1'b0, 32'h0);
    endtask

    task automatic t_flush;  // R11
        logic h; logic [31:0] n;
        fill(32'h0F0, 32'hF0F0, 1'b1);
        push_call(32'h0, 32'h88, 32'h8800);
        flush = 1'b1;
        request(2'b00, 32'h0F0, 32'h0, 32'h0, h, n);
        flush = 1'b0;
        check("R11 request in flush cycle", {63'd0, h}, 64'd0);
        expect_lookup("R11 cache cleared", 2'b00, 32'h0F0, 1'b0, 32'h0);
        expect_lookup("R11 stack emptied", 2'b10, 32'h88, 1'b0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_timing();
        t_branch_basic();
        t_assoc_lru();
        t_update_invalidate();
        t_call_target();
        t_return_stack();
        t_overflow();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule